// File: doc/BRIEF.md
# Nibble Handshake Byte Link

This block carries bytes over a narrow parallel port, four data bits at a time, and paces each half byte with a pair of handshake wires. The local side owns one wire (the strobe output, `th_o`). The remote peer owns the other (the acknowledge input, `tl_i`). Every byte crosses as two nibbles, the low half first and the high half second. The strobe toggles once per nibble. The block waits for the peer's acknowledge level before it captures or drives each half.

On the core side, received bytes appear on `rx_data` with a single-cycle `rx_valid` strobe. Bytes to send are offered on `tx_data` with a `tx_valid`/`tx_ready` handshake. The block also owns the pin directions. When disabled, every pin is an input. While receiving, only the strobe is driven. Before it drives the data pins for sending, it waits until the peer has pulled the acknowledge line low, which shows that the peer is ready to listen. The acknowledge input is synchronised before the block tests its level.

Top module: `nib_link`

## Requirements
- R1: After reset, `th_o`, `th_oe`, `dat_oe`, `tx_ready` and `rx_valid` are all 0.
- R2: While `link_en` is 0, `th_oe` and `dat_oe` are 0 from the next clock edge on, whatever `tl_i` does.
- R3: With `link_en`=1 and `dir_tx`=0 the block receives. `th_oe`=1 and `dat_oe`=0. A byte is assembled as `rx_data[3:0]` = the nibble read first and `rx_data[7:4]` = the nibble read second. It is presented with `rx_valid` high for exactly one cycle.
- R4: While receiving, `th_o` is 0 while the block waits for the low nibble. It rises once the acknowledge has been seen low and that nibble has been taken. It returns to 0 once the acknowledge has been seen high and the high nibble has been taken.
- R5: If `rx_last` is 1 when a high nibble is taken, that byte is still delivered. `th_o` then stays 1 until `link_en` falls.
- R6: When `dir_tx` is 1 in receive mode, `dat_oe` stays 0 until the synchronised acknowledge is low. In that same cycle `dat_oe` and `th_o` both become 1.
- R7: When sending, the block waits for the acknowledge low, then drives `tx_data[3:0]` on `dat_o` with `th_o`=0. It then waits for the acknowledge high and drives `tx_data[7:4]` with `th_o`=1. `dat_o` never changes while `th_o` holds still.
- R8: `tx_ready` drops on the edge that accepts a byte. It returns to 1 only on the edge that drives the high nibble.
- R9: A change of `tl_i` reaches the state logic after `SYNC_STAGES` clock edges, so `th_o` responds on the (`SYNC_STAGES`+1)-th rising edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| link_en | input | 1 | Enables the link; 0 releases every pin to input |
| dir_tx | input | 1 | Requests the send direction |
| rx_last | input | 1 | Marks the byte being received as the final one |
| tl_i | input | 1 | Acknowledge wire from the peer (asynchronous) |
| th_o | output | 1 | Strobe wire value toward the peer |
| th_oe | output | 1 | Output enable of the strobe pin |
| dat_i | input | NIB_W | Data pins as read |
| dat_o | output | NIB_W | Data pins value when driven |
| dat_oe | output | 1 | Output enable of the data pins |
| rx_data | output | 2*NIB_W | Received byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| tx_data | input | 2*NIB_W | Byte to send |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Block can take a byte |

## Verification
A wrong control state shows up at the pins within a nibble period. Three symptoms reveal it: a strobe level that disagrees with the phase the peer expects, data pins enabled before the acknowledge fell, or a `tx_ready` that reappears before the high nibble was driven. The bench's peer model stalls on a wrong strobe level, and the timeout reports it after a few hundred cycles. A swapped or stale nibble register shows at once in the byte compared after each transfer. An off-by-one in the synchroniser shows as a strobe response one edge early or late.

// File: rtl/nib_link_pkg.sv
package nib_link_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX_LO,
      ST_RX_HI,
      ST_RX_END,
      ST_TURN,
      ST_TX_IDLE,
      ST_TX_ARM,
      ST_TX_LO
   } link_st_e;

endpackage

// File: rtl/nib_link_sync.sv
module nib_link_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("nib_link_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/nib_link_ctrl.sv
module nib_link_ctrl
   import nib_link_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic link_en,
   input  logic dir_tx,
   input  logic rx_last,
   input  logic tl_s,
   input  logic tx_valid,
   output logic cap_lo,
   output logic cap_hi,
   output logic tx_load,
   output logic drv_lo,
   output logic drv_hi,
   output logic th_o,
   output logic th_oe,
   output logic dat_oe,
   output logic tx_ready
);

   link_st_e st_q, st_d;

   always_comb begin
      st_d    = st_q;
      cap_lo  = 1'b0;
      cap_hi  = 1'b0;
      tx_load = 1'b0;
      drv_lo  = 1'b0;
      drv_hi  = 1'b0;
      if (!link_en) begin
         st_d = ST_IDLE;
      end else begin
         unique case (st_q)
            ST_IDLE:    st_d = dir_tx ? ST_TURN : ST_RX_LO;
            ST_RX_LO: begin
               if (dir_tx) st_d = ST_TURN;
               else if (!tl_s) begin
                  cap_lo = 1'b1;
                  st_d   = ST_RX_HI;
               end
            end
            ST_RX_HI: begin
               if (tl_s) begin
                  cap_hi = 1'b1;
                  st_d   = rx_last ? ST_RX_END : ST_RX_LO;
               end
            end
            ST_RX_END:  st_d = ST_RX_END;
            ST_TURN:    if (!tl_s) st_d = ST_TX_IDLE;
            ST_TX_IDLE: begin
               if (tx_valid) begin
                  tx_load = 1'b1;
                  st_d    = ST_TX_ARM;
               end
            end
            ST_TX_ARM: begin
               if (!tl_s) begin
                  drv_lo = 1'b1;
                  st_d   = ST_TX_LO;
               end
            end
            ST_TX_LO: begin
               if (tl_s) begin
                  drv_hi = 1'b1;
                  st_d   = ST_TX_IDLE;
               end
            end
            default:    st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign th_o     = (st_q == ST_RX_HI) || (st_q == ST_RX_END) ||
                     (st_q == ST_TX_IDLE) || (st_q == ST_TX_ARM);
   assign th_oe    = (st_q != ST_IDLE);
   assign dat_oe   = (st_q == ST_TX_IDLE) || (st_q == ST_TX_ARM) ||
                     (st_q == ST_TX_LO);
   assign tx_ready = (st_q == ST_TX_IDLE);

endmodule

// File: rtl/nib_link_pack.sv
module nib_link_pack #(
   parameter int NIB_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cap_lo,
   input  logic               cap_hi,
   input  logic               tx_load,
   input  logic               drv_lo,
   input  logic               drv_hi,
   input  logic [NIB_W-1:0]   dat_i,
   input  logic [2*NIB_W-1:0] tx_data,
   output logic [NIB_W-1:0]   dat_o,
   output logic [2*NIB_W-1:0] rx_data,
   output logic               rx_valid
);

   localparam int BYTE_W = 2 * NIB_W;

   logic [NIB_W-1:0]  lo_q;
   logic [BYTE_W-1:0] tx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q     <= '0;
         rx_data  <= '0;
         rx_valid <= 1'b0;
      end else begin
         rx_valid <= cap_hi;
         if (cap_lo) lo_q    <= dat_i;
         if (cap_hi) rx_data <= {dat_i, lo_q};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q  <= '0;
         dat_o <= '0;
      end else begin
         if (tx_load) tx_q  <= tx_data;
         if (drv_lo)       dat_o <= tx_q[NIB_W-1:0];
         else if (drv_hi)  dat_o <= tx_q[BYTE_W-1:NIB_W];
      end
   end

endmodule

// File: rtl/nib_link.sv
module nib_link #(
   parameter int NIB_W       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               link_en,
   input  logic               dir_tx,
   input  logic               rx_last,
   input  logic               tl_i,
   output logic               th_o,
   output logic               th_oe,
   input  logic [NIB_W-1:0]   dat_i,
   output logic [NIB_W-1:0]   dat_o,
   output logic               dat_oe,
   output logic [2*NIB_W-1:0] rx_data,
   output logic               rx_valid,
   input  logic [2*NIB_W-1:0] tx_data,
   input  logic               tx_valid,
   output logic               tx_ready
);

   generate
      if (NIB_W < 1) begin : g_bad_width
         $error("nib_link: NIB_W must be positive");
      end
   endgenerate

   logic tl_s;
   logic cap_lo, cap_hi, tx_load, drv_lo, drv_hi;

   nib_link_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (tl_i),
      .q     (tl_s)
   );

   nib_link_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .link_en  (link_en),
      .dir_tx   (dir_tx),
      .rx_last  (rx_last),
      .tl_s     (tl_s),
      .tx_valid (tx_valid),
      .cap_lo   (cap_lo),
      .cap_hi   (cap_hi),
      .tx_load  (tx_load),
      .drv_lo   (drv_lo),
      .drv_hi   (drv_hi),
      .th_o     (th_o),
      .th_oe    (th_oe),
      .dat_oe   (dat_oe),
      .tx_ready (tx_ready)
   );

   nib_link_pack #(.NIB_W(NIB_W)) u_pack (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_lo   (cap_lo),
      .cap_hi   (cap_hi),
      .tx_load  (tx_load),
      .drv_lo   (drv_lo),
      .drv_hi   (drv_hi),
      .dat_i    (dat_i),
      .tx_data  (tx_data),
      .dat_o    (dat_o),
      .rx_data  (rx_data),
      .rx_valid (rx_valid)
   );

endmodule

// File: rtl/nib_link_chk.sv
module nib_link_chk #(
   parameter int NIB_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             link_en,
   input logic             th_o,
   input logic             th_oe,
   input logic [NIB_W-1:0] dat_o,
   input logic             dat_oe,
   input logic             rx_valid,
   input logic             tx_valid,
   input logic             tx_ready
);

   // R2
   idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !link_en |=> (!th_oe && !dat_oe));

   // R3
   rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   // R6
   data_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dat_oe |-> th_oe);

   // R6
   turn_strobe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dat_oe) |-> th_o);

   // R7
   data_moves_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_oe && $past(dat_oe) && !$stable(dat_o)) |-> !$stable(th_o));

   // R8
   ready_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |=> !tx_ready);

endmodule

bind nib_link nib_link_chk #(.NIB_W(NIB_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .link_en  (link_en),
   .th_o     (th_o),
   .th_oe    (th_oe),
   .dat_o    (dat_o),
   .dat_oe   (dat_oe),
   .rx_valid (rx_valid),
   .tx_valid (tx_valid),
   .tx_ready (tx_ready)
);

// File: tb/tb_nib_link.sv
module tb_nib_link;

   localparam int NIB_W = 4;
   localparam int SYNC  = 2;
   localparam int BW    = 2 * NIB_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic link_en = 1'b0, dir_tx = 1'b0, rx_last = 1'b0, tl_i = 1'b1;
   logic [NIB_W-1:0] dat_i = '0;
   logic [BW-1:0] tx_data = '0;
   logic tx_valid = 1'b0;
   logic th_o, th_oe, dat_oe, rx_valid, tx_ready;
   logic [NIB_W-1:0] dat_o;
   logic [BW-1:0] rx_data;

   int compared = 0, mismatched = 0, cycles = 0, rx_cnt = 0;
   logic [BW-1:0] last_rx = '0;
   bit done = 0;

   always #2 clk = ~clk;

   nib_link #(.NIB_W(NIB_W), .SYNC_STAGES(SYNC)) dut (
      .clk(clk), .rst_n(rst_n), .link_en(link_en), .dir_tx(dir_tx),
      .rx_last(rx_last), .tl_i(tl_i), .th_o(th_o), .th_oe(th_oe),
      .dat_i(dat_i), .dat_o(dat_o), .dat_oe(dat_oe), .rx_data(rx_data),
      .rx_valid(rx_valid), .tx_data(tx_data), .tx_valid(tx_valid),
      .tx_ready(tx_ready)
   );

   always @(negedge clk) begin
      cycles = cycles + 1;
      if (rx_valid) begin
         last_rx = rx_data;
         rx_cnt  = rx_cnt + 1;
      end
   end

   function automatic logic [BW-1:0] join_nib(input logic [NIB_W-1:0] hi,
                                              input logic [NIB_W-1:0] lo);
      return {hi, lo};
   endfunction

   function automatic logic [NIB_W-1:0] lo_of(input logic [BW-1:0] b);
      return b[NIB_W-1:0];
   endfunction

   function automatic logic [NIB_W-1:0] hi_of(input logic [BW-1:0] b);
      return b[BW-1:NIB_W];
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cycles);
      end
   endtask

   task automatic wait_th(input logic lvl, input string req);
      int n = 0;
      while (th_o !== lvl && n < 300) begin
         @(negedge clk);
         n++;
      end
      if (th_o !== lvl) chk({req, " strobe level timeout"}, th_o, lvl);
   endtask

   // peer sends one byte toward the block (R3, R4)
   task automatic peer_put(input logic [BW-1:0] b);
      wait_th(1'b0, "R4");
      dat_i = lo_of(b);
      tl_i  = 1'b0;
      wait_th(1'b1, "R4");
      dat_i = hi_of(b);
      tl_i  = 1'b1;
   endtask

   task automatic rx_expect(input logic [BW-1:0] b, input int cnt);
      repeat (SYNC + 3) @(negedge clk);
      chk("R3 byte count", rx_cnt, cnt);
      chk("R3 byte value", last_rx, b);
   endtask

   // block sends one byte, peer collects it (R7, R8)
   task automatic tx_put(input logic [BW-1:0] b);
      logic [NIB_W-1:0] lo, hi;
      int n = 0;
      tx_data  = b;
      tx_valid = 1'b1;
      while (tx_ready !== 1'b1 && n < 300) begin @(negedge clk); n++; end
      @(negedge clk);
      tx_valid = 1'b0;
      chk("R8 ready low after accept", tx_ready, 1'b0);
      tl_i = 1'b0;
      wait_th(1'b0, "R7");
      lo = dat_o;
      chk("R8 ready low between nibbles", tx_ready, 1'b0);
      chk("R7 data pins driven", dat_oe, 1'b1);
      tl_i = 1'b1;
      wait_th(1'b1, "R7");
      hi = dat_o;
      chk("R8 ready back with high nibble", tx_ready, 1'b1);
      chk("R7 byte on pins", join_nib(hi, lo), b);
   endtask

   initial begin
      int seen;
      logic [BW-1:0] b;
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      // R1
      chk("R1 th_o", th_o, 1'b0);
      chk("R1 th_oe", th_oe, 1'b0);
      chk("R1 dat_oe", dat_oe, 1'b0);
      chk("R1 tx_ready", tx_ready, 1'b0);
      chk("R1 rx_valid", rx_valid, 1'b0);
      rst_n = 1'b1;

      // R2: idle with acknowledge activity
      for (int i = 0; i < 6; i++) begin
         tl_i = ~tl_i;
         repeat (3) @(negedge clk);
         chk("R2 idle th_oe", th_oe, 1'b0);
         chk("R2 idle dat_oe", dat_oe, 1'b0);
      end
      tl_i = 1'b1;
      repeat (SYNC + 1) @(negedge clk);

      // R3 receive mode pin directions
      link_en = 1'b1;
      repeat (2) @(negedge clk);
      chk("R3 th_oe", th_oe, 1'b1);
      chk("R3 dat_oe", dat_oe, 1'b0);
      chk("R4 strobe low waiting", th_o, 1'b0);

      // R9 latency, R4 strobe rise, first byte directed
      dat_i = 4'h3;
      tl_i  = 1'b0;
      seen  = 0;
      for (int k = 1; k <= 8; k++) begin
         @(negedge clk);
         if (th_o === 1'b1 && seen == 0) seen = k;
      end
      chk("R9 strobe response edges", seen, SYNC + 1);
      dat_i = 4'hC;
      tl_i  = 1'b1;
      rx_expect(8'hC3, 1);
      chk("R4 strobe low after byte", th_o, 1'b0);

      // directed and random receive
      peer_put(8'h00); rx_expect(8'h00, 2);
      peer_put(8'hFF); rx_expect(8'hFF, 3);
      peer_put(8'hA5); rx_expect(8'hA5, 4);
      peer_put(8'h5A); rx_expect(8'h5A, 5);
      for (int i = 0; i < 24; i++) begin
         b = BW'($urandom);
         peer_put(b);
         rx_expect(b, 6 + i);
      end

      // R5 last byte keeps strobe high
      rx_last = 1'b1;
      peer_put(8'h96);
      rx_expect(8'h96, 30);
      rx_last = 1'b0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (th_o !== 1'b1) begin chk("R5 strobe held high", th_o, 1'b1); break; end
      end
      chk("R5 strobe still high", th_o, 1'b1);

      link_en = 1'b0;
      repeat (2) @(negedge clk);
      chk("R2 released th_oe", th_oe, 1'b0);
      chk("R2 released dat_oe", dat_oe, 1'b0);

      // R6 turnaround
      link_en = 1'b1;
      dir_tx  = 1'b1;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (dat_oe !== 1'b0) begin chk("R6 early data enable", dat_oe, 1'b0); break; end
      end
      chk("R6 data held as input", dat_oe, 1'b0);
      chk("R6 strobe driven", th_oe, 1'b1);
      tl_i = 1'b0;
      seen = 0;
      for (int k = 1; k <= 8; k++) begin
         @(negedge clk);
         if (dat_oe === 1'b1 && seen == 0) begin
            seen = k;
            chk("R6 strobe high with data enable", th_o, 1'b1);
         end
      end
      chk("R6 enable edges after acknowledge low", seen, SYNC + 1);
      chk("R8 ready after turnaround", tx_ready, 1'b1);

      // transmit directed and random
      tx_put(8'h00);
      tx_put(8'hFF);
      tx_put(8'h1E);
      tx_put(8'hE1);
      for (int i = 0; i < 16; i++) tx_put(BW'($urandom));

      link_en = 1'b0;
      dir_tx  = 1'b0;
      repeat (2) @(negedge clk);
      chk("R2 final th_oe", th_oe, 1'b0);
      chk("R2 final dat_oe", dat_oe, 1'b0);

      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         done = 1;
         compared++;
         mismatched++;
         $display("FAIL watchdog: actual running, expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

endmodule